// File: doc/BRIEF.md
# Snoop Response and Fill-State Logic

This block sits beside a snooping cache controller on a split-transaction address bus and handles the shared-line handshake. Every address tenure opens with a one-cycle start strobe. The response window is the single cycle two clock cycles after that strobe. For addresses that another master puts on the bus, the block looks at the local lookup result and a reservation match. From these it drives a shared line and an address-retry line, each with its own output enable. It also flags an Exclusive-to-Shared downgrade for the cache.

For the controller's own transactions, the block samples the shared and retry inputs in the response window. From them it reports the coherency state for the incoming line, or it reports that the transaction must be reissued. When a snoop hits a Modified line, the block retries the snooping master and records the victim address in a one-entry push queue. That push then has to go out as the controller's next address transaction. While the push is waiting, other core requests are held back.

State encoding used throughout: 2'b00 Invalid, 2'b01 Shared, 2'b10 Exclusive, 2'b11 Modified. Transaction types 3'b000 (read) and 3'b001 (read-atomic) count as reads. Every other type code is a non-read.

Top module: `snoop_share_resp`

## Requirements
- R1: While `share_en` is low at the strobe, `shr_out` stays low in that transaction's window, and an own read never reports fill state Shared (2'b01).
- R2: For an own read or read-atomic (`txn_type` 3'b000 or 3'b001), if `rty_in` is low and `shr_in` is high in the window, `fill_valid` pulses in the next cycle with `fill_state` = 2'b01 (Shared), provided `share_en` was high at the strobe.
- R3: For an own read or read-atomic with `rty_in` low and `shr_in` low in the window, `fill_valid` pulses in the next cycle with `fill_state` = 2'b10 (Exclusive).
- R4: An own transaction of any other type code never raises `fill_valid`, whatever `shr_in` does.
- R5: If `rty_in` is high in the window of an own transaction, `reissue` pulses in the next cycle and `fill_valid` stays low; `shr_in` is ignored.
- R6: For a snooped address, `shr_out` is high in the window exactly when `share_en` is high and either the lookup state is Shared, Exclusive or Modified, or a valid reservation matches the address. An Invalid line with no reservation match drives both lines negated.
- R7: A snooped read or read-atomic that finds an Exclusive line with `share_en` high raises `dg_valid` in the window, with `dg_addr` equal to the snooped address.
- R8: A snooped hit on a Modified line raises `rty_out` in the window. If the queue is empty, `push_req` rises in the next cycle with `push_addr` equal to the snooped address. While `push_req` is high, `core_ok` is low.
- R9: While a push is queued, further Modified hits still raise `rty_out` but leave `push_addr` unchanged. `push_taken` clears `push_req` in the next cycle.
- R10: `shr_oe` and `rty_oe` are high together only in the window of a snooped (not own) transaction. In every other cycle they are low, and both data lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| share_en | input | 1 | Shared-state support enable, sampled at the strobe |
| addr_start | input | 1 | Address tenure start strobe |
| own_txn | input | 1 | Tenure belongs to this controller |
| txn_type | input | TW | Transaction type code |
| addr_bus | input | AW | Tenure address |
| snoop_state | input | 2 | Local lookup state for the address, valid with the strobe |
| resv_valid | input | 1 | Reservation held |
| resv_addr | input | AW | Reserved address |
| shr_in | input | 1 | Shared line as received |
| rty_in | input | 1 | Retry line as received |
| shr_out | output | 1 | Shared line drive value |
| shr_oe | output | 1 | Shared line output enable |
| rty_out | output | 1 | Retry line drive value |
| rty_oe | output | 1 | Retry line output enable |
| fill_valid | output | 1 | Own read completed; fill state valid |
| fill_state | output | 2 | State for the incoming line |
| reissue | output | 1 | Own transaction was retried |
| dg_valid | output | 1 | Downgrade local Exclusive line to Shared |
| dg_addr | output | AW | Address to downgrade |
| push_req | output | 1 | Modified-line push pending, highest priority |
| push_addr | output | AW | Victim address to push |
| push_taken | input | 1 | Push address tenure issued |
| core_req | input | 1 | Other pending request from the core |
| core_ok | output | 1 | Core request may be issued |

## Verification
The assertions check, on every cycle, the properties that depend only on port timing. The output enables open only in the window two cycles after a snooped strobe, and a disabled shared mode never drives `shr_out`. A Modified hit always retries. A retried window never gives a fill, a Shared fill always follows an asserted `shr_in`, and `core_ok` is held back behind a queued push. Only the bench's scenarios can show the rest: the exact choice between Shared and Exclusive fills, the reservation-driven shared response, the downgrade address, and that a second Modified hit leaves the queued victim address untouched until the push is taken. These scenarios combine random transactions with directed corner cases.

// File: rtl/snoop_share_resp.sv
module snoop_share_resp #(
  parameter int AW = 32,
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          share_en,
  input  logic          addr_start,
  input  logic          own_txn,
  input  logic [TW-1:0] txn_type,
  input  logic [AW-1:0] addr_bus,
  input  logic [1:0]    snoop_state,
  input  logic          resv_valid,
  input  logic [AW-1:0] resv_addr,
  input  logic          shr_in,
  input  logic          rty_in,
  output logic          shr_out,
  output logic          shr_oe,
  output logic          rty_out,
  output logic          rty_oe,
  output logic          fill_valid,
  output logic [1:0]    fill_state,
  output logic          reissue,
  output logic          dg_valid,
  output logic [AW-1:0] dg_addr,
  output logic          push_req,
  output logic [AW-1:0] push_addr,
  input  logic          push_taken,
  input  logic          core_req,
  output logic          core_ok
);
  localparam logic [1:0] ST_I = 2'b00;
  localparam logic [1:0] ST_S = 2'b01;
  localparam logic [1:0] ST_E = 2'b10;
  localparam logic [1:0] ST_M = 2'b11;
  localparam logic [TW-1:0] T_RD  = TW'(0);
  localparam logic [TW-1:0] T_RDA = TW'(1);

  logic is_rd, resv_hit, snoop;
  assign is_rd    = (txn_type == T_RD) || (txn_type == T_RDA);
  assign resv_hit = resv_valid && (resv_addr == addr_bus);
  assign snoop    = addr_start && !own_txn;

  logic          s1_vld, s1_own, s1_shr, s1_rty, s1_dg, s1_fill, s1_en;
  logic [AW-1:0] s1_addr;
  logic          s2_vld, s2_own, s2_shr, s2_rty, s2_dg, s2_fill, s2_en;
  logic [AW-1:0] s2_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0; s1_own <= 1'b0; s1_shr <= 1'b0; s1_rty <= 1'b0;
      s1_dg  <= 1'b0; s1_fill <= 1'b0; s1_en <= 1'b0; s1_addr <= '0;
    end else begin
      s1_vld  <= addr_start;
      s1_own  <= addr_start && own_txn;
      s1_shr  <= snoop && share_en && ((snoop_state != ST_I) || resv_hit);
      s1_rty  <= snoop && (snoop_state == ST_M);
      s1_dg   <= snoop && share_en && is_rd && (snoop_state == ST_E);
      s1_fill <= addr_start && own_txn && is_rd;
      s1_en   <= share_en;
      s1_addr <= addr_bus;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_vld <= 1'b0; s2_own <= 1'b0; s2_shr <= 1'b0; s2_rty <= 1'b0;
      s2_dg  <= 1'b0; s2_fill <= 1'b0; s2_en <= 1'b0; s2_addr <= '0;
    end else begin
      s2_vld  <= s1_vld;
      s2_own  <= s1_own;
      s2_shr  <= s1_shr;
      s2_rty  <= s1_rty;
      s2_dg   <= s1_dg;
      s2_fill <= s1_fill;
      s2_en   <= s1_en;
      s2_addr <= s1_addr;
    end
  end

  logic win_snp, win_own;
  assign win_snp = s2_vld && !s2_own;
  assign win_own = s2_vld && s2_own;

  assign shr_oe   = win_snp;
  assign rty_oe   = win_snp;
  assign shr_out  = win_snp && s2_shr;
  assign rty_out  = win_snp && s2_rty;
  assign dg_valid = win_snp && s2_dg;
  assign dg_addr  = s2_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_valid <= 1'b0;
      fill_state <= ST_I;
      reissue    <= 1'b0;
    end else begin
      fill_valid <= win_own && s2_fill && !rty_in;
      reissue    <= win_own && rty_in;
      if (win_own && s2_fill && !rty_in)
        fill_state <= (s2_en && shr_in) ? ST_S : ST_E;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      push_req  <= 1'b0;
      push_addr <= '0;
    end else if (!push_req && win_snp && s2_rty) begin
      push_req  <= 1'b1;
      push_addr <= s2_addr;
    end else if (push_req && push_taken) begin
      push_req  <= 1'b0;
    end
  end

  assign core_ok = core_req && !push_req;
endmodule

module snoop_share_chk #(
  parameter int AW = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       share_en,
  input logic       addr_start,
  input logic       own_txn,
  input logic [1:0] snoop_state,
  input logic       shr_in,
  input logic       rty_in,
  input logic       shr_out,
  input logic       shr_oe,
  input logic       rty_out,
  input logic       rty_oe,
  input logic       fill_valid,
  input logic [1:0] fill_state,
  input logic       push_req,
  input logic       core_ok
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_oe_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(addr_start, 2) && !$past(own_txn, 2)) |-> (shr_oe && rty_oe));
  p_oe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !$past(addr_start, 2)) |-> (!shr_oe && !rty_oe && !shr_out && !rty_out));
  p_no_share_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(addr_start, 2) && !$past(share_en, 2)) |-> !shr_out);
  p_mod_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(addr_start, 2) && !$past(own_txn, 2) && ($past(snoop_state, 2) == 2'b11))
      |-> (rty_out && (shr_out == $past(share_en, 2))));
  p_retry_no_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(rty_in)) |-> !fill_valid);
  p_shared_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && fill_valid && (fill_state == 2'b01)) |-> $past(shr_in));
  p_push_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> !core_ok);
endmodule

bind snoop_share_resp snoop_share_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .share_en(share_en), .addr_start(addr_start),
  .own_txn(own_txn), .snoop_state(snoop_state), .shr_in(shr_in), .rty_in(rty_in),
  .shr_out(shr_out), .shr_oe(shr_oe), .rty_out(rty_out), .rty_oe(rty_oe),
  .fill_valid(fill_valid), .fill_state(fill_state), .push_req(push_req),
  .core_ok(core_ok)
);

// File: tb/tb_snoop_share_resp.sv
module tb_snoop_share_resp;
  localparam int AW = 32;
  localparam int TW = 3;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          share_en = 1'b1;
  logic          addr_start = 1'b0;
  logic          own_txn = 1'b0;
  logic [TW-1:0] txn_type = '0;
  logic [AW-1:0] addr_bus = '0;
  logic [1:0]    snoop_state = 2'b00;
  logic          resv_valid = 1'b0;
  logic [AW-1:0] resv_addr = '0;
  logic          shr_in = 1'b0;
  logic          rty_in = 1'b0;
  logic          shr_out, shr_oe, rty_out, rty_oe;
  logic          fill_valid, reissue, dg_valid, push_req, core_ok;
  logic [1:0]    fill_state;
  logic [AW-1:0] dg_addr, push_addr;
  logic          push_taken = 1'b0;
  logic          core_req = 1'b0;

  int checks = 0;
  int fails = 0;
  logic          m_pend = 1'b0;
  logic [AW-1:0] m_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_share_resp #(.AW(AW), .TW(TW)) dut (.*);

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic f_rd(input logic [TW-1:0] t);
    return (t == 3'b000) || (t == 3'b001);
  endfunction

  function automatic logic f_shr(input logic en, input logic [1:0] st, input logic rh);
    return en && ((st != 2'b00) || rh);
  endfunction

  function automatic logic [1:0] f_fill(input logic en, input logic sh);
    return (en && sh) ? 2'b01 : 2'b10;
  endfunction

  task automatic txn(input logic own, input logic [TW-1:0] ty, input logic [AW-1:0] a,
                     input logic [1:0] st, input logic rh, input logic en,
                     input logic si, input logic ri, input logic take, input logic creq);
    logic rd;
    rd = f_rd(ty);
    @(negedge clk);
    addr_start = 1'b1; own_txn = own; txn_type = ty; addr_bus = a;
    snoop_state = st; share_en = en;
    resv_valid = rh; resv_addr = rh ? a : ~a;
    @(negedge clk);
    addr_start = 1'b0; addr_bus = $urandom; snoop_state = 2'($urandom);
    chk("R10 oe before window", {30'd0, shr_oe, rty_oe}, '0);
    @(negedge clk);
    shr_in = si; rty_in = ri;
    #1;
    if (own) begin
      chk("R10 oe released on own window", {30'd0, shr_oe, rty_oe}, '0);
    end else begin
      chk("R10 oe in snoop window", {30'd0, shr_oe, rty_oe}, 32'd3);
      chk(en ? "R6 shared out" : "R1 shared out disabled", AW'(shr_out), AW'(f_shr(en, st, rh)));
      chk("R8 retry out", AW'(rty_out), AW'(st == 2'b11));
      chk("R7 downgrade", AW'(dg_valid), AW'(en && rd && st == 2'b10));
      if (en && rd && st == 2'b10) chk("R7 downgrade addr", dg_addr, a);
    end
    @(negedge clk);
    shr_in = 1'b0; rty_in = 1'b0;
    if (!own && st == 2'b11 && !m_pend) begin
      m_pend = 1'b1; m_addr = a;
    end
    core_req = creq;
    #1;
    if (own) begin
      chk(rd ? (ri ? "R5 no fill on retry" : "R2/R3 fill valid") : "R4 no fill on non-read",
          AW'(fill_valid), AW'(rd && !ri));
      chk("R5 reissue", AW'(reissue), AW'(ri));
      if (rd && !ri)
        chk(si ? (en ? "R2 fill shared" : "R1 fill not shared") : "R3 fill exclusive",
            AW'(fill_state), AW'(f_fill(en, si)));
    end else begin
      chk("R4 no fill on snoop", AW'(fill_valid), '0);
    end
    chk("R8 push req", AW'(push_req), AW'(m_pend));
    if (m_pend) chk("R9 push addr held", push_addr, m_addr);
    chk("R8 core gated", AW'(core_ok), AW'(creq && !m_pend));
    push_taken = take && m_pend;
    @(negedge clk);
    if (push_taken) m_pend = 1'b0;
    push_taken = 1'b0; core_req = 1'b0;
    #1;
    chk("R9 push after take", AW'(push_req), AW'(m_pend));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset oe", {30'd0, shr_oe, rty_oe}, '0);
    chk("R8 reset push", AW'(push_req), '0);
    chk("R2 reset fill", AW'(fill_valid), '0);
    rst_n = 1'b1;
    // directed corner cases
    txn(1'b1, 3'b000, 32'h100, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); // R2
    txn(1'b1, 3'b001, 32'h140, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); // R3
    txn(1'b1, 3'b000, 32'h180, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // R1
    txn(1'b1, 3'b101, 32'h1c0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // R4
    txn(1'b1, 3'b000, 32'h200, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // R5
    txn(1'b0, 3'b000, 32'h240, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R6 reservation
    txn(1'b0, 3'b000, 32'h280, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R6 invalid
    txn(1'b0, 3'b001, 32'h2c0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R7
    txn(1'b0, 3'b000, 32'h300, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); // R8
    txn(1'b0, 3'b000, 32'h340, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); // R9 second hit
    txn(1'b0, 3'b010, 32'h380, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1); // R9 take
    txn(1'b0, 3'b000, 32'h3c0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R1 snoop
    // random mix
    void'($urandom(32'h5eed));
    for (int i = 0; i < 400; i++) begin
      txn(1'($urandom), 3'($urandom % 4), {$urandom} & 32'hffff_ffc0, 2'($urandom),
          ($urandom % 4) == 0, ($urandom % 5) != 0, 1'($urandom), ($urandom % 4) == 0,
          ($urandom % 3) == 0, 1'($urandom));
    end
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule